// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block sits at the front of a 64-bit load/store pipeline whose only addressing mode is a base register plus a signed 16-bit offset. Each request names an access kind (32-bit long, 64-bit quad, or unaligned-quad), a load/store direction, a 64-bit base value and a 16-bit offset. One cycle after acceptance the block presents the following results:

- the memory address;
- an access-size code;
- a flag asking the load path to sign-extend a 32-bit result;
- an alignment-fault flag;
- a memory request strobe, which is held low whenever the fault is raised.

The unaligned-quad kind never faults. It rounds the computed address down to an 8-byte boundary instead, which lets software fetch the quad that encloses any byte. Long and quad accesses fault when their address is misaligned. Byte and word kinds do not exist, and the fourth kind code is rejected with a fault.

A valid/ready handshake on each side allows back-pressure. One register stage sustains one request per cycle.

Top module: `ls_addr_gen`

## Requirements
- R1: The address equals base plus the offset sign-extended to 64 bits, taken modulo 2^64. A carry out of bit 63 is dropped and not reported. This applies to every kind except unaligned-quad (see R6).
- R2: Offset 0x8000 yields base minus 32768. Offset 0x7FFF yields base plus 32767.
- R3: The kind code on `in_kind` is 0 for long, 1 for quad, 2 for unaligned-quad and 3 for reserved. `out_size` gives log2 of the access bytes: 2 for long, 3 for quad and unaligned-quad, and 0 for reserved. `out_store` echoes `in_store`.
- R4: `out_sext` is 1 only for a long load (kind 0 with `in_store`=0), and 0 for every other request.
- R5: A long access faults when address bits [1:0] are nonzero. A quad access faults when address bits [2:0] are nonzero. Otherwise neither faults.
- R6: For unaligned-quad, the address is the sum with bits [2:0] forced to zero, and it never faults. For example, base 0x1234 with offset 3 gives 0x1230.
- R7: Kind 3 always raises `out_fault`.
- R8: `out_req` is 1 exactly when `out_valid` is 1 and `out_fault` is 0.
- R9: A request accepted on one clock edge appears on `out_valid` after that edge. Results leave in acceptance order. Outputs stay stable while `out_valid`=1 and `out_ready`=0. `in_ready` equals `!out_valid || out_ready`.
- R10: While `rst` is high, and after it is released with no request accepted, `out_valid` and `out_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_kind | input | 2 | Access kind code (R3) |
| in_store | input | 1 | 1 = store, 0 = load |
| in_base | input | 64 | Base register value |
| in_disp | input | 16 | Signed byte offset |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_req | output | 1 | Memory request strobe |
| out_addr | output | 64 | Memory address |
| out_size | output | 2 | log2 of access bytes |
| out_store | output | 1 | Direction of the access |
| out_sext | output | 1 | Sign-extend the 32-bit load result |
| out_fault | output | 1 | Alignment or illegal-kind fault |

## Verification
The hardest case to reach is a result that is stalled by the consumer while a new request is already waiting on the input. That case tests whether the held address stays stable and whether the waiting request is held off, then accepted in order. The stimulus drops `out_ready` at random about a quarter of the time while the producer keeps issuing. This keeps the output register full under pressure for many cycles.

A directed set is sent first. It covers:
- the most negative and most positive offsets;
- a base that wraps past 2^64;
- the 0x1234 + 3 rounding case;
- misaligned long and quad addresses;
- the reserved kind.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  typedef enum logic [1:0] {
    ACC_LONG  = 2'd0,
    ACC_QUAD  = 2'd1,
    ACC_UQUAD = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam logic [1:0] SZ_NONE = 2'd0;
  localparam logic [1:0] SZ_4B   = 2'd2;
  localparam logic [1:0] SZ_8B   = 2'd3;
endpackage

// File: rtl/agu_sum.sv
module agu_sum #(
  parameter int AW = 64,
  parameter int DW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] sum
);
  localparam int EXT_W = AW - DW;

  logic [AW-1:0] disp_ext;

  // sign-extend the offset, then add; the carry out is dropped
  assign disp_ext = {{EXT_W{disp[DW-1]}}, disp};
  assign sum      = base + disp_ext;
endmodule

// File: rtl/agu_decode.sv
module agu_decode
  import ls_agu_pkg::*;
#(
  parameter int AW     = 64,
  parameter int LONG_B = 2,
  parameter int QUAD_B = 3
) (
  input  logic [1:0]    kind,
  input  logic          store,
  input  logic [AW-1:0] sum,
  output logic [AW-1:0] addr,
  output logic [1:0]    size,
  output logic          sext,
  output logic          fault
);
  localparam logic [AW-1:0] QUAD_MASK = ~((AW'(1) << QUAD_B) - AW'(1));

  logic long_mis;
  logic quad_mis;

  // only the low bits of the sum feed the alignment checks
  assign long_mis = |sum[LONG_B-1:0];
  assign quad_mis = |sum[QUAD_B-1:0];

  always_comb begin
    addr  = sum;
    size  = SZ_NONE;
    sext  = 1'b0;
    fault = 1'b0;
    unique case (acc_kind_e'(kind))
      ACC_LONG: begin
        size  = SZ_4B;
        sext  = ~store;
        fault = long_mis;
      end
      ACC_QUAD: begin
        size  = SZ_8B;
        fault = quad_mis;
      end
      ACC_UQUAD: begin
        size  = SZ_8B;
        addr  = sum & QUAD_MASK;
      end
      default: begin
        fault = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/agu_stage.sv
module agu_stage
  import ls_agu_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] d_addr,
  input  logic [1:0]    d_size,
  input  logic          d_store,
  input  logic          d_sext,
  input  logic          d_fault,
  input  logic [1:0]    d_kind,
  output logic          q_valid,
  input  logic          q_ready,
  output logic [AW-1:0] q_addr,
  output logic [1:0]    q_size,
  output logic          q_store,
  output logic          q_sext,
  output logic          q_fault
);
  logic [1:0] q_kind;

  assign in_ready = ~q_valid | q_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else if (in_ready) begin
      q_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      q_addr  <= d_addr;
      q_size  <= d_size;
      q_store <= d_store;
      q_sext  <= d_sext;
      q_fault <= d_fault;
      q_kind  <= d_kind;
    end
  end

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
    q_valid && !q_ready |=> q_valid && $stable(q_addr) && $stable(q_fault) && $stable(q_size)); // R9

  AST_UQUAD_NEVER_FAULTS: assert property (@(posedge clk) disable iff (rst)
    q_valid && q_kind == ACC_UQUAD |-> !q_fault && q_addr[2:0] == 3'd0); // R6

  AST_RSVD_FAULTS: assert property (@(posedge clk) disable iff (rst)
    q_valid && q_kind == ACC_RSVD |-> q_fault); // R7
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_agu_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic          in_store,
  input  logic [AW-1:0] in_base,
  input  logic [DW-1:0] in_disp,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_req,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    out_size,
  output logic          out_store,
  output logic          out_sext,
  output logic          out_fault
);
  logic [AW-1:0] sum;
  logic [AW-1:0] d_addr;
  logic [1:0]    d_size;
  logic          d_sext;
  logic          d_fault;

  agu_sum #(.AW(AW), .DW(DW)) u_sum (
    .base (in_base),
    .disp (in_disp),
    .sum  (sum)
  );

  agu_decode #(.AW(AW)) u_dec (
    .kind  (in_kind),
    .store (in_store),
    .sum   (sum),
    .addr  (d_addr),
    .size  (d_size),
    .sext  (d_sext),
    .fault (d_fault)
  );

  agu_stage #(.AW(AW)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d_addr   (d_addr),
    .d_size   (d_size),
    .d_store  (in_store),
    .d_sext   (d_sext),
    .d_fault  (d_fault),
    .d_kind   (in_kind),
    .q_valid  (out_valid),
    .q_ready  (out_ready),
    .q_addr   (out_addr),
    .q_size   (out_size),
    .q_store  (out_store),
    .q_sext   (out_sext),
    .q_fault  (out_fault)
  );

  // a faulting access never reaches memory
  assign out_req = out_valid & ~out_fault;

  AST_LONG_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_size == SZ_4B && !out_fault |-> out_addr[1:0] == 2'd0); // R5

  AST_QUAD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_size == SZ_8B && !out_fault |-> out_addr[2:0] == 3'd0); // R5

  AST_SEXT_LONG_LOAD: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sext |-> out_size == SZ_4B && !out_store); // R4

  AST_ACCEPT_SHOWS_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R9
endmodule

// File: tb/ls_addr_gen_bench.sv
module ls_addr_gen_bench;
  typedef struct {
    logic [63:0] addr;
    logic [1:0]  size;
    logic        store;
    logic        sext;
    logic        fault;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_store;
  logic [1:0]  in_kind;
  logic [63:0] in_base;
  logic [15:0] in_disp;
  logic        out_valid, out_ready, out_req, out_store, out_sext, out_fault;
  logic [63:0] out_addr;
  logic [1:0]  out_size;

  int n_checks = 0;
  int n_fail   = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  ls_addr_gen u_ls_addr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_store(in_store), .in_base(in_base), .in_disp(in_disp),
    .out_valid(out_valid), .out_ready(out_ready), .out_req(out_req),
    .out_addr(out_addr), .out_size(out_size), .out_store(out_store),
    .out_sext(out_sext), .out_fault(out_fault)
  );

  function automatic exp_t model(logic [1:0] k, logic st, logic [63:0] b, logic [15:0] d);
    exp_t e;
    logic [63:0] s;
    s = b + 64'($signed(d));
    e.addr = s; e.store = st; e.sext = 1'b0; e.fault = 1'b0;
    case (k)
      2'd0: begin e.size = 2'd2; e.sext = !st; e.fault = (s % 4) != 0; end
      2'd1: begin e.size = 2'd3; e.fault = (s % 8) != 0; end
      2'd2: begin e.size = 2'd3; e.addr = s - (s % 8); end
      default: begin e.size = 2'd0; e.fault = 1'b1; end
    endcase
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  localparam int ND = 8;
  localparam int TOTAL = 600;
  logic [1:0]  dk [ND];
  logic        ds [ND];
  logic [63:0] db [ND];
  logic [15:0] dd [ND];

  initial begin
    // R6 rounding example
    dk[0] = 2'd2; ds[0] = 0; db[0] = 64'h1234;              dd[0] = 16'h0003;
    // R2 most negative offset, R4 long load
    dk[1] = 2'd0; ds[1] = 0; db[1] = 64'h1000;              dd[1] = 16'h8000;
    // R2 most positive offset, R5 misaligned quad
    dk[2] = 2'd1; ds[2] = 1; db[2] = 64'h100;               dd[2] = 16'h7FFF;
    // R1 wrap past 2^64
    dk[3] = 2'd1; ds[3] = 0; db[3] = 64'hFFFF_FFFF_FFFF_FFFF; dd[3] = 16'h0001;
    // R5 misaligned long store
    dk[4] = 2'd0; ds[4] = 1; db[4] = 64'h2002;              dd[4] = 16'h0000;
    // R7 reserved kind
    dk[5] = 2'd3; ds[5] = 0; db[5] = 64'h4000;              dd[5] = 16'h0010;
    // R6 store, wrapped sum
    dk[6] = 2'd2; ds[6] = 1; db[6] = 64'hFFFF_FFFF_FFFF_FFFF; dd[6] = 16'h7FFF;
    // R4 long load, negative offset
    dk[7] = 2'd0; ds[7] = 0; db[7] = 64'h10;                dd[7] = 16'hFFFC;
  end

  initial begin
    int   n_sent = 0;
    int   cyc = 0;
    bit   hold = 0;
    bit   was_stalled = 0;
    bit   acc_prev = 0;
    logic [63:0] held_addr = '0;
    exp_t e;
    exp_t h;

    rst = 1; in_valid = 0; in_kind = 0; in_store = 0; in_base = 0; in_disp = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R10 out_valid in reset", 64'(out_valid), 64'd0);
    check(out_req == 0,   "R10 out_req in reset",   64'(out_req),   64'd0);
    rst = 0;
    @(negedge clk);
    #1;
    check(out_valid == 0, "R10 out_valid after reset", 64'(out_valid), 64'd0);

    while ((n_sent < TOTAL || q.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (!hold) begin
        if (n_sent < TOTAL && ($urandom % 4) != 0) begin
          in_valid = 1;
          if (n_sent < ND) begin
            in_kind = dk[n_sent]; in_store = ds[n_sent]; in_base = db[n_sent]; in_disp = dd[n_sent];
          end else begin
            in_kind  = 2'($urandom);
            in_store = 1'($urandom);
            in_base  = (($urandom % 8) == 0) ? 64'hFFFF_FFFF_FFFF_FF00 | 64'($urandom % 256)
                                             : {$urandom, $urandom};
            in_disp  = 16'($urandom);
          end
        end else begin
          in_valid = 0;
        end
      end
      out_ready = ($urandom % 4) != 0;
      #1;

      check(in_ready == (!out_valid || out_ready), "R9 in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
      check(out_req == (out_valid && !out_fault), "R8 out_req", 64'(out_req), 64'(out_valid && !out_fault));
      if (acc_prev)
        check(out_valid == 1, "R9 valid after accept", 64'(out_valid), 64'd1);
      if (was_stalled) begin
        check(out_valid == 1 && out_addr == held_addr, "R9 stall hold", out_addr, held_addr);
      end

      if (out_valid) begin
        if (q.size() == 0) begin
          check(0, "R9 unexpected result", out_addr, 64'd0);
        end else begin
          h = q[0];
          check(out_addr == h.addr,   "R1/R2/R6 address", out_addr, h.addr);
          check(out_size == h.size,   "R3 size",          64'(out_size), 64'(h.size));
          check(out_store == h.store, "R3 store echo",    64'(out_store), 64'(h.store));
          check(out_sext == h.sext,   "R4 sext",          64'(out_sext), 64'(h.sext));
          check(out_fault == h.fault, "R5/R6/R7 fault",   64'(out_fault), 64'(h.fault));
          if (out_ready) void'(q.pop_front());
        end
      end
      was_stalled = out_valid && !out_ready;
      held_addr   = out_addr;

      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        e = model(in_kind, in_store, in_base, in_disp);
        q.push_back(e);
        n_sent++;
        hold = 0;
      end else begin
        hold = in_valid;
      end
    end

    if (cyc >= 20000) check(0, "R9 watchdog expired", 64'(cyc), 64'(20000));
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule